// File: doc/BRIEF.md
# Interrupt Pad Trigger Latch

This block takes one external, non-maskable interrupt pad and turns it into a sticky, active-high request line for a downstream interrupt controller. The pad is first brought into the clock domain by a short synchroniser. Under a selectable trigger type it is then optionally inverted and optionally edge-detected. A qualifying event sets a set/reset latch. The latch output drives the downstream line directly, so the controller always sees a level-high request, whichever pad trigger type is in use.

Software uses a small register port to reach the block. A 2-bit type field selects level-low, falling-edge, level-high or rising-edge triggering. Writing a one to bit 0 of the pending register clears the latch. Reading that same bit returns the latch gated by bit 0 of the enable register. In the level types, a pad that is still asserted sets the latch again at once, so a clear only takes hold after the source lets go. Changing the trigger type never produces an event on its own.

Top module: `nmi_trigger_latch`

## Requirements
- R1: After a synchronous active-low reset: `irq_level_o` is 0, the type field (offset 0x0C, bits 1:0) reads 0, enable bit 0 (offset 0x40) reads 1, and pending bit 0 (offset 0x10) reads 0.
- R2: With type 0 (level low), a low pad sets `irq_level_o`. A pad change driven before clock edge N shows at the output after edge N+2 and not before.
- R3: With type 1 (falling edge), a high-to-low pad transition sets the latch. A pad that stays low after a clear does not set it again.
- R4: With type 2 (level high), a high pad sets the latch.
- R5: With type 3 (rising edge), a low-to-high pad transition sets the latch. A pad that stays high after a clear does not set it again.
- R6: A write with bit 0 = 1 to offset 0x10 clears the latch on that clock edge. A write with bit 0 = 0 leaves it unchanged. Without a clear, the latch holds its value after the pad returns to idle.
- R7: In the level types, a clear issued while the pad is still asserted leaves the latch set.
- R8: When a clear write and a qualifying event fall on the same clock edge, the latch is set.
- R9: Pending bit 0 at 0x10 reads as the latch AND enable bit 0 at 0x40. The enable bit does not gate `irq_level_o`. Unmapped read bits are 0.
- R10: Writing a new type value produces no event by itself, even when the inversion of the held pad level flips under the new type.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_i | input | 1 | Asynchronous interrupt pad |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| irq_level_o | output | 1 | Latched active-high request to the downstream controller |

## Verification
A latch that is wrongly set or cleared shows on `irq_level_o` on the very next clock edge. It also shows at once on the pending read at 0x10, so every cycle of a random pad sequence compares both against a model that tracks pad history through the three-edge latency. A stale edge history or a missed type-change suppression shows up as a spurious set within one cycle of the type write. Directed cases cover the same-edge set/clear race and level re-assertion, whose effect is visible on the edge after the write.

// File: rtl/nmi_trig_pkg.sv
// Shared types and register offsets for the interrupt pad trigger latch.
// Assumes byte offsets fit in the address width chosen by the top.
package nmi_trig_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_LO    = 2'd0,
        TRIG_EDGE_FALL = 2'd1,
        TRIG_LVL_HI    = 2'd2,
        TRIG_EDGE_RISE = 2'd3
    } trig_mode_e;

    localparam int OFS_CTRL = 'h0C;
    localparam int OFS_PEND = 'h10;
    localparam int OFS_ENAB = 'h40;

    // True when the selected type treats a low pad as active.
    function automatic logic mode_inverts(trig_mode_e m);
        return (m == TRIG_LVL_LO) || (m == TRIG_EDGE_FALL);
    endfunction

    // True when the selected type reacts to transitions only.
    function automatic logic mode_is_edge(trig_mode_e m);
        return (m == TRIG_EDGE_FALL) || (m == TRIG_EDGE_RISE);
    endfunction

endpackage

// File: rtl/nmi_pad_sync.sv
// Multi-flop synchroniser for the asynchronous pad.
// Assumes STAGES >= 2; flops reset to the pad's idle level so that no
// event is seen straight after reset.
module nmi_pad_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain;

    // Shift the pad value through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{IDLE_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], pad_i};
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/nmi_trig_detect.sv
// Inversion and edge detection for the synchronised pad.
// Produces a one-cycle (edge types) or continuous (level types) event.
// The history register follows the qualified value every cycle, and the
// cycle in which the type changes is masked for edge types.
module nmi_trig_detect
    import nmi_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  trig_mode_e mode_i,
    output logic       evt_o
);

    logic       qual;
    logic       hist_q;
    trig_mode_e mode_q;
    logic       mode_chg;

    // Qualified pad value: active-high under the selected type.
    always_comb begin
        qual = mode_inverts(mode_i) ? ~sync_i : sync_i;
    end

    assign mode_chg = (mode_i != mode_q);

    // Track previous qualified value and previous type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= 1'b0;
            mode_q <= TRIG_LVL_LO;
        end else begin
            hist_q <= qual;
            mode_q <= mode_i;
        end
    end

    // Event: level follows the qualified value; edge needs a 0->1 step
    // under an unchanged type.
    always_comb begin
        if (mode_is_edge(mode_i)) begin
            evt_o = qual & ~hist_q & ~mode_chg;
        end else begin
            evt_o = qual;
        end
    end

endmodule

// File: rtl/nmi_req_latch.sv
// Set/reset request latch; set has priority over a same-cycle clear.
module nmi_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    logic q;

    // Capture events, drop on clear unless an event arrives together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= set_i | (q & ~clr_i);
        end
    end

    assign q_o = q;

endmodule

// File: rtl/nmi_ctrl_regs.sv
// Register port: type field, write-one-to-clear pending, enable bit.
// Assumes single-cycle writes and a combinational read of reg_addr.
module nmi_ctrl_regs
    import nmi_trig_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CTRL_OFS = OFS_CTRL,
    parameter int PEND_OFS = OFS_PEND,
    parameter int ENAB_OFS = OFS_ENAB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              latch_i,
    output logic [DATA_W-1:0] rdata_o,
    output trig_mode_e        mode_o,
    output logic              en_o,
    output logic              clr_o
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_OFS);
    localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(ENAB_OFS);

    trig_mode_e mode_q;
    logic       en_q;
    logic       unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:2];

    // Hold the type field and enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= TRIG_LVL_LO;
            en_q   <= 1'b1;
        end else if (wr_i) begin
            if (addr_i == A_CTRL) mode_q <= trig_mode_e'(wdata_i[1:0]);
            if (addr_i == A_ENAB) en_q   <= wdata_i[0];
        end
    end

    assign clr_o  = wr_i && (addr_i == A_PEND) && wdata_i[0];
    assign mode_o = mode_q;
    assign en_o   = en_q;

    // Read mux; unmapped offsets and bits return zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CTRL) rdata_o[1:0] = mode_q;
        if (addr_i == A_PEND) rdata_o[0]   = latch_i & en_q;
        if (addr_i == A_ENAB) rdata_o[0]   = en_q;
    end

endmodule

// File: rtl/nmi_trigger_latch.sv
// Top: pad synchroniser -> trigger detect -> request latch, with a
// small register port. Output is always an active-high level.
// Assumes PAD_IDLE is the pad level that is inactive under the reset type.
module nmi_trigger_latch
    import nmi_trig_pkg::*;
#(
    parameter int   ADDR_W      = 8,
    parameter int   DATA_W      = 32,
    parameter int   SYNC_STAGES = 2,
    parameter logic PAD_IDLE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_level_o
);

    logic       pad_sync;
    logic       trig_evt;
    logic       latch_q;
    logic       clr_req;
    logic       en_bit;
    trig_mode_e ctrl_mode;

    nmi_pad_sync #(
        .STAGES   (SYNC_STAGES),
        .IDLE_VAL (PAD_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_i),
        .sync_o (pad_sync)
    );

    nmi_trig_detect u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (pad_sync),
        .mode_i (ctrl_mode),
        .evt_o  (trig_evt)
    );

    nmi_req_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (trig_evt),
        .clr_i (clr_req),
        .q_o   (latch_q)
    );

    nmi_ctrl_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .latch_i (latch_q),
        .rdata_o (reg_rdata),
        .mode_o  (ctrl_mode),
        .en_o    (en_bit),
        .clr_o   (clr_req)
    );

    assign irq_level_o = latch_q;

endmodule

// File: rtl/nmi_trigger_latch_chk.sv
// Property checker for the trigger latch, bound to the top.
module nmi_trigger_latch_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wdata0,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic              set_evt,
    input logic              en,
    input logic [1:0]        trig_mode
);

    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(nmi_trig_pkg::OFS_PEND);

    logic clr_wr;
    assign clr_wr = reg_wr && (reg_addr == A_PEND) && wdata0;

    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(set_evt)); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> irq); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !set_evt) |=> !irq); // R6

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq); // R6

    AST_PEND_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_PEND) |-> (reg_rdata == {{(DATA_W-1){1'b0}}, irq & en})); // R9

    AST_NO_TYPE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode[0] && (trig_mode != $past(trig_mode))) |-> !set_evt); // R10

endmodule

bind nmi_trigger_latch nmi_trigger_latch_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wdata0    (reg_wdata[0]),
    .reg_rdata (reg_rdata),
    .irq       (irq_level_o),
    .set_evt   (trig_evt),
    .en        (en_bit),
    .trig_mode (ctrl_mode)
);

// File: tb/nmi_trigger_latch_test.sv
module nmi_trigger_latch_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] A_CTRL = 8'h0C;
    localparam logic [ADDR_W-1:0] A_PEND = 8'h10;
    localparam logic [ADDR_W-1:0] A_ENAB = 8'h40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pad = 1'b1;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    nmi_trigger_latch uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pad_i       (pad),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_level_o (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Qualified (active) pad level under a type, per R2-R5 encodings.
    function automatic logic active_lvl(logic [1:0] t, logic p);
        return (t == 2'd0 || t == 2'd1) ? ~p : p;
    endfunction

    function automatic logic is_edge(logic [1:0] t);
        return t[0];
    endfunction

    task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear();
        wr(A_PEND, 32'h1);
    endtask

    // Random segment under a fixed type, compared to a cycle model.
    task automatic rand_segment(logic [1:0] t, int cycles);
        logic s1, s2, hq, lat, ev, clr;
        pad = active_lvl(t, 1'b0) ? 1'b1 : 1'b0;
        repeat (4) tick();
        wr(A_CTRL, {30'b0, t});
        repeat (4) tick();
        clear();
        check("R6 segment start clear", {31'b0, irq}, 32'h0);
        s1 = pad; s2 = pad; hq = active_lvl(t, pad); lat = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            if ($urandom_range(0, 7) == 0) pad = ~pad;
            clr = ($urandom_range(0, 15) == 0);
            reg_wr = clr; reg_addr = A_PEND; reg_wdata = {31'b0, clr};
            @(posedge clk);
            ev = is_edge(t) ? (active_lvl(t, s2) & ~hq) : active_lvl(t, s2);
            lat = ev | (lat & ~clr);
            hq = active_lvl(t, s2);
            s2 = s1;
            s1 = pad;
            @(negedge clk);
            reg_wr = 1'b0; reg_wdata = '0;
            check(t == 0 ? "R2 random" : t == 1 ? "R3 random" : t == 2 ? "R4 random" : "R5 random",
                  {31'b0, irq}, {31'b0, lat});
            #1 check("R9 random pending", reg_rdata, {31'b0, lat});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        void'($urandom(32'd1234));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_CTRL, d); check("R1 type", d, 32'h0);
        rd(A_ENAB, d); check("R1 enable", d, 32'h1);
        rd(A_PEND, d); check("R1 pending", d, 32'h0);

        // R2 level low, latency of three edges
        pad = 1'b0;
        tick(); tick();
        check("R2 not before latency", {31'b0, irq}, 32'h0);
        tick();
        check("R2 level low set", {31'b0, irq}, 32'h1);
        rd(A_PEND, d); check("R9 pending set", d, 32'h1);
        // R7 clear while still asserted
        clear();
        check("R7 level re-set", {31'b0, irq}, 32'h1);
        pad = 1'b1;
        repeat (3) tick();
        check("R6 sticky after idle", {31'b0, irq}, 32'h1);
        wr(A_PEND, 32'h0);
        check("R6 write zero ignored", {31'b0, irq}, 32'h1);
        // R9 enable gates view only
        wr(A_ENAB, 32'h0);
        rd(A_PEND, d); check("R9 pending gated", d, 32'h0);
        check("R9 irq not gated", {31'b0, irq}, 32'h1);
        rd(A_ENAB, d); check("R9 enable reads 0", d, 32'h0);
        wr(A_ENAB, 32'h1);
        clear();
        check("R6 clear", {31'b0, irq}, 32'h0);

        // R4 level high
        pad = 1'b0;
        tick();
        wr(A_CTRL, 32'h2);
        rd(A_CTRL, d); check("R4 type readback", d, 32'h2);
        repeat (3) tick();
        clear();
        check("R4 idle clear", {31'b0, irq}, 32'h0);
        pad = 1'b1;
        repeat (3) tick();
        check("R4 level high set", {31'b0, irq}, 32'h1);
        pad = 1'b0;
        repeat (3) tick();
        clear();
        check("R4 clear", {31'b0, irq}, 32'h0);

        // R5 rising edge
        wr(A_CTRL, 32'h3);
        repeat (3) tick();
        clear();
        pad = 1'b1;
        repeat (3) tick();
        check("R5 rising set", {31'b0, irq}, 32'h1);
        clear();
        repeat (4) tick();
        check("R5 steady high no re-set", {31'b0, irq}, 32'h0);

        // R3 falling edge
        wr(A_CTRL, 32'h1);
        repeat (3) tick();
        check("R10 rise->fall high pad", {31'b0, irq}, 32'h0);
        pad = 1'b0;
        repeat (3) tick();
        check("R3 falling set", {31'b0, irq}, 32'h1);
        clear();
        repeat (4) tick();
        check("R3 steady low no re-set", {31'b0, irq}, 32'h0);

        // R10 type change with low pad: falling type sees pad as active
        wr(A_CTRL, 32'h3);
        repeat (3) tick();
        clear();
        wr(A_CTRL, 32'h1);
        repeat (4) tick();
        check("R10 no false edge", {31'b0, irq}, 32'h0);

        // R8 set wins over same-edge clear (rising type)
        wr(A_CTRL, 32'h3);
        repeat (3) tick();
        pad = 1'b1;
        repeat (3) tick();
        check("R8 pre-set", {31'b0, irq}, 32'h1);
        pad = 1'b0;
        repeat (3) tick();
        pad = 1'b1;
        tick(); tick();
        clear();
        check("R8 set wins", {31'b0, irq}, 32'h1);
        clear();
        check("R8 later clear", {31'b0, irq}, 32'h0);

        // Random phases under every type
        for (int t = 0; t < 4; t++) begin
            rand_segment(t[1:0], 400);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule